// File: doc/BRIEF.md
# Snooping Three-State Coherence Controller

This block keeps one write-back cache coherent with its peers on a shared snooping bus using an invalidation protocol. Each line of a small direct-mapped tag/state store is Invalid, Shared (clean, read-only) or Exclusive (dirty, writable, sole copy). The CPU side presents one access at a time over a valid/ready request channel and receives a one-cycle response that says whether the access hit without bus traffic. Accesses that need the bus raise a request and wait for a grant. They then issue read-miss, write-miss or write-back commands, one per granted cycle.

Every cycle the controller also watches the command another cache puts on the bus. A peer's miss that lands on one of its dirty lines makes it supply the block (write-back) and tell memory to abandon its own reply. A peer's write miss invalidates any local copy. No line changes state for a CPU access before the bus is granted. A waiting access is re-evaluated against the line as it is at grant time, so a snoop that hits the line first is serviced and the access restarts.

Request back-pressure: `cpu_req_ready` is high only while no access is outstanding, and a request is taken in a cycle where both valid and ready are high. The response channel has no back-pressure: `cpu_rsp_valid` pulses for exactly one cycle per accepted request.

Top module: `msi_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is 1, `bus_req` is 0, `bus_cmd` is 0 and `cpu_rsp_valid` is 0.
- R2: A read to a line not present issues a read-miss command (code 1) and leaves the line Shared. A later read of that address responds with hit=1 and no bus command.
- R3: A write to a line that is Invalid or Shared issues a write-miss command (code 2) and responds with hit=0, leaving the line Exclusive. A read or write hit on an Exclusive line responds with hit=1 and no bus command.
- R4: A snooped write miss to a Shared line invalidates it without write-back, so the next local access to that address misses.
- R5: A snooped read miss to an Exclusive line asserts `snp_wb` and `snp_abort` in that cycle and leaves the line Shared.
- R6: A snooped write miss to an Exclusive line asserts `snp_wb` and `snp_abort` in that cycle and leaves the line Invalid.
- R7: A miss whose index holds an Exclusive line with a different tag first issues a write-back command (code 3) carrying the old line's address, then the read or write miss for the new address.
- R8: A line's state does not change for a CPU access before `bus_gnt`. If a snoop changes the line while the access waits, the access is re-evaluated at grant, and a write-back no longer needed is not issued.
- R9: `bus_cmd` is non-zero only in a cycle where `bus_req` and `bus_gnt` are both high, with one command per such cycle. Codes are 0 none, 1 read miss, 2 write miss, 3 write back. The address index is the low `IDX_W` bits of the address and the tag is the rest.
- R10: Each accepted request produces exactly one `cpu_rsp_valid` pulse, and no new request is accepted until it has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU access request valid |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_wr | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Block address of the access |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_hit | output | 1 | Access completed without bus traffic |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_cmd | output | 2 | Command driven while granted |
| bus_addr | output | ADDR_W | Address of the driven command |
| snp_cmd | input | 2 | Command another cache drives on the bus |
| snp_addr | input | ADDR_W | Address of the snooped command |
| snp_wb | output | 1 | This cache supplies the dirty block |
| snp_abort | output | 1 | Memory must drop its reply |

## Verification
Two controllers share one bus, and the bench walks them through ownership hand-overs in both directions. The first corner case is a write to a clean Shared copy. A design that treated it as a silent hit would leave the peer's stale copy valid, and the peer's later read would hit instead of missing. Snooped misses on dirty lines are checked for the write-back and abort flags. A design that skipped them would let memory answer with stale data. Misses into an index held dirty under another tag must show the write-back of the old address first. The restart case puts a dirty conflicting line under a peer's write miss while its own request waits for the bus. A design that decided its commands at request time would then write back a block it no longer owns.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_state_t;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_ARB  = 1'b1
  } ctl_state_t;

  localparam logic [1:0] BC_NONE   = 2'd0;
  localparam logic [1:0] BC_RDMISS = 2'd1;
  localparam logic [1:0] BC_WRMISS = 2'd2;
  localparam logic [1:0] BC_WBACK  = 2'd3;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cpu_idx,
  output line_state_t       cpu_state,
  output logic [TAG_W-1:0]  cpu_tag,
  input  logic [IDX_W-1:0]  snp_idx,
  output line_state_t       snp_state,
  output logic [TAG_W-1:0]  snp_tag,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_state_t       wr_state,
  input  logic [TAG_W-1:0]  wr_tag
);
  localparam int NLINES = 1 << IDX_W;

  line_state_t      st_q  [NLINES];
  logic [TAG_W-1:0] tag_q [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]  <= LS_INV;
        tag_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        st_q[g]  <= wr_state;
        tag_q[g] <= wr_tag;
      end
    end
  end

  assign cpu_state = st_q[cpu_idx];
  assign cpu_tag   = tag_q[cpu_idx];
  assign snp_state = st_q[snp_idx];
  assign snp_tag   = tag_q[snp_idx];
endmodule

// File: rtl/msi_snoop_resp.sv
module msi_snoop_resp
  import msi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        cmd,
  input  logic [TAG_W-1:0]  addr_tag,
  input  line_state_t       line_state,
  input  logic [TAG_W-1:0]  line_tag,
  output logic              upd,
  output line_state_t       upd_state,
  output logic              supply
);
  logic match;
  assign match = enable && line_state != LS_INV && line_tag == addr_tag;

  always_comb begin
    upd       = 1'b0;
    upd_state = line_state;
    supply    = 1'b0;
    if (match) begin
      if (cmd == BC_RDMISS && line_state == LS_EXC) begin
        upd = 1'b1; upd_state = LS_SHR; supply = 1'b1;
      end else if (cmd == BC_WRMISS) begin
        upd = 1'b1; upd_state = LS_INV; supply = (line_state == LS_EXC);
      end
    end
  end

  // R5 / R6: a supplied block always answers a peer's miss, never a write-back
  assert_supply_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    supply |-> (cmd == BC_RDMISS || cmd == BC_WRMISS));
  assert_supply_only_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    supply |-> line_state == LS_EXC);
endmodule

// File: rtl/msi_coherence_ctrl.sv
module msi_coherence_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_wr,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_rsp_valid,
  output logic              cpu_rsp_hit,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_wb,
  output logic              snp_abort
);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_state_t        ctl_q;
  logic              pend_wr_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              rsp_valid_q, rsp_hit_q;

  logic              idle, granted, accept;
  logic [ADDR_W-1:0] look_addr;
  logic              look_wr;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  line_state_t       line_state, snp_line_state;
  logic [TAG_W-1:0]  line_tag, snp_line_tag;
  logic              line_match, quiet_hit, need_wb, finish;

  logic              own_we;
  line_state_t       own_state;
  logic [TAG_W-1:0]  own_tag;
  logic              snp_upd;
  line_state_t       snp_upd_state;
  logic              snp_supply;

  logic              st_we;
  logic [IDX_W-1:0]  st_idx;
  line_state_t       st_state;
  logic [TAG_W-1:0]  st_tag;

  assign idle      = (ctl_q == CTL_IDLE);
  assign granted   = !idle && bus_gnt;
  assign accept    = idle && cpu_req_valid;
  assign look_addr = idle ? cpu_req_addr : pend_addr_q;
  assign look_wr   = idle ? cpu_req_wr : pend_wr_q;
  assign look_idx  = look_addr[IDX_W-1:0];
  assign look_tag  = look_addr[ADDR_W-1:IDX_W];

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cpu_idx(look_idx), .cpu_state(line_state), .cpu_tag(line_tag),
    .snp_idx(snp_addr[IDX_W-1:0]), .snp_state(snp_line_state), .snp_tag(snp_line_tag),
    .wr_en(st_we), .wr_idx(st_idx), .wr_state(st_state), .wr_tag(st_tag)
  );

  msi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .enable(!granted), .cmd(snp_cmd), .addr_tag(snp_addr[ADDR_W-1:IDX_W]),
    .line_state(snp_line_state), .line_tag(snp_line_tag),
    .upd(snp_upd), .upd_state(snp_upd_state), .supply(snp_supply)
  );

  assign line_match = line_state != LS_INV && line_tag == look_tag;
  assign quiet_hit  = line_match && (line_state == LS_EXC || !look_wr);
  assign need_wb    = line_state == LS_EXC && !line_match;

  // Decision is taken from the line as it is in the granted cycle (restart rule)
  always_comb begin
    own_we    = 1'b0;
    own_state = LS_INV;
    own_tag   = line_tag;
    bus_cmd   = BC_NONE;
    bus_addr  = '0;
    finish    = 1'b0;
    if (granted) begin
      if (quiet_hit) begin
        finish = 1'b1;
      end else if (need_wb) begin
        bus_cmd  = BC_WBACK;
        bus_addr = {line_tag, look_idx};
        own_we   = 1'b1;
      end else begin
        bus_cmd   = look_wr ? BC_WRMISS : BC_RDMISS;
        bus_addr  = pend_addr_q;
        own_we    = 1'b1;
        own_state = look_wr ? LS_EXC : LS_SHR;
        own_tag   = look_tag;
        finish    = 1'b1;
      end
    end
  end

  assign st_we    = own_we || snp_upd;
  assign st_idx   = own_we ? look_idx : snp_addr[IDX_W-1:0];
  assign st_state = own_we ? own_state : snp_upd_state;
  assign st_tag   = own_we ? own_tag : snp_line_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q       <= CTL_IDLE;
      pend_wr_q   <= 1'b0;
      pend_addr_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        if (quiet_hit) begin
          rsp_valid_q <= 1'b1;
          rsp_hit_q   <= 1'b1;
        end else begin
          ctl_q       <= CTL_ARB;
          pend_wr_q   <= cpu_req_wr;
          pend_addr_q <= cpu_req_addr;
        end
      end else if (finish) begin
        ctl_q       <= CTL_IDLE;
        rsp_valid_q <= 1'b1;
        rsp_hit_q   <= quiet_hit;
      end
    end
  end

  assign cpu_req_ready = idle;
  assign bus_req       = !idle;
  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_hit   = rsp_hit_q;
  assign snp_wb        = snp_supply;
  assign snp_abort     = snp_supply;

  assert_cmd_when_granted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd != BC_NONE |-> (bus_req && bus_gnt));
  assert_wback_is_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd == BC_WBACK |-> line_state == LS_EXC);
  assert_miss_after_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_hit) |-> $past(bus_gnt));
  assert_rsp_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> $past(bus_req || cpu_req_valid));
  assert_single_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid || $past(cpu_req_valid));
endmodule

// File: tb/msi_coherence_ctrl_test.sv
`timescale 1ns/1ps
module msi_coherence_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic       req_v [2];
  logic       req_w [2];
  logic [7:0] req_a [2];
  logic       rdy [2], rsp_v [2], rsp_h [2], breq [2], gnt [2], wb [2], ab [2];
  logic [1:0] cmd [2];
  logic [7:0] badr [2];

  // fixed-priority bench arbiter, instance 0 first
  assign gnt[0] = breq[0];
  assign gnt[1] = breq[1] && !breq[0];

  msi_coherence_ctrl #(.ADDR_W(8), .IDX_W(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(req_v[0]), .cpu_req_ready(rdy[0]), .cpu_req_wr(req_w[0]), .cpu_req_addr(req_a[0]),
    .cpu_rsp_valid(rsp_v[0]), .cpu_rsp_hit(rsp_h[0]),
    .bus_req(breq[0]), .bus_gnt(gnt[0]), .bus_cmd(cmd[0]), .bus_addr(badr[0]),
    .snp_cmd(cmd[1]), .snp_addr(badr[1]), .snp_wb(wb[0]), .snp_abort(ab[0])
  );
  msi_coherence_ctrl #(.ADDR_W(8), .IDX_W(2)) peer (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(req_v[1]), .cpu_req_ready(rdy[1]), .cpu_req_wr(req_w[1]), .cpu_req_addr(req_a[1]),
    .cpu_rsp_valid(rsp_v[1]), .cpu_rsp_hit(rsp_h[1]),
    .bus_req(breq[1]), .bus_gnt(gnt[1]), .bus_cmd(cmd[1]), .bus_addr(badr[1]),
    .snp_cmd(cmd[0]), .snp_addr(badr[0]), .snp_wb(wb[1]), .snp_abort(ab[1])
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // vector: who, wr, addr, hit, ncmd, first cmd, first cmd addr, peer supplied
  localparam int VW = 1 + 1 + 8 + 1 + 2 + 2 + 8 + 1;
  localparam int NV = 16;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0,1'b0,8'h10,1'b0,2'd1,2'd1,8'h10,1'b0},  // R2 read miss from invalid
    {1'b0,1'b0,8'h10,1'b1,2'd0,2'd0,8'h00,1'b0},  // R2 read hit shared
    {1'b1,1'b0,8'h10,1'b0,2'd1,2'd1,8'h10,1'b0},  // R2 second sharer
    {1'b1,1'b1,8'h10,1'b0,2'd1,2'd2,8'h10,1'b0},  // R3 write to shared = miss
    {1'b0,1'b0,8'h10,1'b0,2'd1,2'd1,8'h10,1'b1},  // R4 was invalidated, R5 peer supplies
    {1'b1,1'b1,8'h10,1'b0,2'd1,2'd2,8'h10,1'b0},  // R5 peer left shared
    {1'b1,1'b1,8'h10,1'b1,2'd0,2'd0,8'h00,1'b0},  // R3 write hit exclusive
    {1'b0,1'b1,8'h10,1'b0,2'd1,2'd2,8'h10,1'b1},  // R6 write miss takes dirty line
    {1'b0,1'b0,8'h10,1'b1,2'd0,2'd0,8'h00,1'b0},  // R3 read hit exclusive
    {1'b0,1'b0,8'h20,1'b0,2'd2,2'd3,8'h10,1'b0},  // R7 conflict read
    {1'b1,1'b0,8'h10,1'b0,2'd1,2'd1,8'h10,1'b0},  // R6 peer was invalidated
    {1'b0,1'b1,8'h05,1'b0,2'd1,2'd2,8'h05,1'b0},  // R3 write from invalid
    {1'b1,1'b0,8'h05,1'b0,2'd1,2'd1,8'h05,1'b1},  // R5 read miss on dirty
    {1'b0,1'b1,8'h20,1'b0,2'd1,2'd2,8'h20,1'b0},  // R3 upgrade, other tag untouched
    {1'b0,1'b1,8'h10,1'b0,2'd2,2'd3,8'h20,1'b0},  // R7 conflict write
    {1'b1,1'b0,8'h10,1'b0,2'd1,2'd1,8'h10,1'b1}   // R5 supply after conflict fill
  };

  task automatic do_op(input int who, input bit wr, input logic [7:0] addr,
                       output bit hit, output int ncmd, output logic [1:0] first,
                       output logic [7:0] faddr, output bit sup, output bit abt);
    bit done = 1'b0;
    hit = 1'b0; ncmd = 0; first = 2'd0; faddr = 8'h00; sup = 1'b0; abt = 1'b0;
    @(negedge clk);
    req_v[who] = 1'b1; req_w[who] = wr; req_a[who] = addr;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      req_v[who] = 1'b0;
      if (cmd[who] != 2'd0) begin
        if (ncmd == 0) begin first = cmd[who]; faddr = badr[who]; end
        ncmd++;
      end
      if (wb[1-who]) sup = 1'b1;
      if (ab[1-who]) abt = 1'b1;
      if (rsp_v[who]) begin hit = rsp_h[who]; done = 1'b1; break; end
    end
    if (!done) chk("R10 response timeout", 0, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit hit, sup, abt;
    int ncmd;
    logic [1:0] first;
    logic [7:0] faddr;
    for (int k = 0; k < 2; k++) begin req_v[k] = 0; req_w[k] = 0; req_a[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'd0, rdy[0] & rdy[1]}, 1);
    chk("R1 bus_req", {31'd0, breq[0] | breq[1]}, 0);
    chk("R1 bus_cmd", {30'd0, cmd[0] | cmd[1]}, 0);
    chk("R1 rsp", {31'd0, rsp_v[0] | rsp_v[1]}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      string tag;
      e = VEC[v];
      do_op(int'(e[23]), e[22], e[21:14], hit, ncmd, first, faddr, sup, abt);
      tag = $sformatf("vec%0d", v);
      chk({tag, " hit R2/R3"}, {31'd0, hit}, {31'd0, e[13]});
      chk({tag, " ncmd R9/R7"}, ncmd, {30'd0, e[12:11]});
      chk({tag, " first cmd R9"}, {30'd0, first}, {30'd0, e[10:9]});
      chk({tag, " first addr R7"}, {24'd0, faddr}, {24'd0, e[8:1]});
      chk({tag, " peer wb R5/R6"}, {31'd0, sup}, {31'd0, e[0]});
      chk({tag, " peer abort R5/R6"}, {31'd0, abt}, {31'd0, e[0]});
    end

    // R8 restart: peer holds 0x20 dirty at index 0 and waits to read 0x10,
    // while uut wins the bus with a write miss to 0x20.
    do_op(1, 1'b1, 8'h20, hit, ncmd, first, faddr, sup, abt);
    chk("R8 setup cmd", {30'd0, first}, 2);
    @(negedge clk);
    req_v[0] = 1'b1; req_w[0] = 1'b1; req_a[0] = 8'h20;
    req_v[1] = 1'b1; req_w[1] = 1'b0; req_a[1] = 8'h10;
    @(negedge clk);
    req_v[0] = 1'b0; req_v[1] = 1'b0;
    chk("R9 uut granted write miss", {30'd0, cmd[0]}, 2);
    chk("R9 peer silent while waiting", {30'd0, cmd[1]}, 0);
    chk("R6 peer supplies dirty", {31'd0, wb[1] & ab[1]}, 1);
    chk("R8 peer still requesting", {31'd0, breq[1]}, 1);
    @(negedge clk);
    chk("R10 uut response", {31'd0, rsp_v[0]}, 1);
    chk("R8 restarted as read miss", {30'd0, cmd[1]}, 1);
    chk("R8 restarted addr", {24'd0, badr[1]}, 8'h10);
    @(negedge clk);
    chk("R10 peer response", {31'd0, rsp_v[1]}, 1);
    chk("R8 peer miss", {31'd0, rsp_h[1]}, 0);
    @(negedge clk);
    chk("R10 single pulse", {31'd0, rsp_v[1]}, 0);
    // R4: uut's write left it sole owner; its own write now hits quietly
    do_op(0, 1'b1, 8'h20, hit, ncmd, first, faddr, sup, abt);
    chk("R3 exclusive write hit", {31'd0, hit}, 1);
    chk("R3 no traffic", ncmd, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule